// File: doc/BRIEF.md
# Four-parent scan stimulus sequencer for clustered-pattern self-test

This block drives a scan-based self-test in which the applied patterns gather around four deterministic centre patterns. For each pattern it loads the scan chains bit by bit, then applies one functional capture cycle. The first pattern of each group is the centre pattern itself. The patterns after it are children: copies of that centre with some bits inverted by an external random flip source.

No centre pattern is held in storage. Each one comes from a comparison between the two low bits of the down-counting shift position and the two top bits of the pattern counter. Those two top bits name the active centre. The lower CHILD_BITS bits of the pattern counter count the patterns inside a group, so the whole run applies 4 × 2^CHILD_BITS patterns. Chain ordering, chain inversion and response compaction are handled by logic outside this block.

Top module: `star_bist_seq`

## Requirements
- R1: During reset and in the idle state, scan_en, capture_en, child_en, done and scan_in are all 0.
- R2: A start pulse in the idle or done state leads to one load cycle with scan_en low. CHAIN_LEN shift cycles with scan_en high follow. The shift position counts down from CHAIN_LEN to 1, one step per shift cycle.
- R3: During a shift cycle with child_en at 0, scan_in is 0 exactly when the two low bits of the shift position equal the centre index. The centre index is the top two bits of the pattern counter, which selects centre 0, 1, 2 and 3 in that order. In every other such shift cycle scan_in is 1. The first bit shifted in belongs to position CHAIN_LEN.
- R4: During a shift cycle with child_en at 1, scan_in equals the R3 waveform bit XOR flip_in.
- R5: After the last shift cycle, exactly one capture cycle follows, with capture_en high and scan_en low. Each capture advances the pattern counter by one.
- R6: child_en is 0 for the whole pattern whose in-group count (the low CHILD_BITS bits of the pattern counter) is zero, and 1 for every other pattern. The first pattern of each group is therefore its centre pattern, unaltered.
- R7: After 4 × 2^CHILD_BITS captures the pattern counter wraps to zero, the block enters the done state and done stays 1 until the next start.
- R8: A start in the done state begins a fresh run from pattern 0 and centre 0.
- R9: start has no effect while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle or done |
| flip_in | input | 1 | Random inversion request from an external generator |
| scan_en | output | 1 | High during shift cycles |
| scan_in | output | 1 | Serial bit into the scan chains |
| capture_en | output | 1 | High for the single capture cycle of each pattern |
| child_en | output | 1 | High while the current pattern is a child |
| done | output | 1 | High once all patterns have been applied |

## Verification
The most exposed points are the group boundaries. There the pattern counter carries into the centre index and child_en must drop for exactly one pattern while the flip source is still toggling. The bench drives flip_in from a free-running pseudorandom sequence, so a child_en that stays high would corrupt the centre pattern visibly. It rebuilds each centre from the comparison rule and compares it bit for bit. Start pulses are injected in the middle of a shift phase and again once done has been reached. These cover the cases where start must be ignored and where it must restart the run from pattern zero.

// File: rtl/star_bist_seq.sv
module star_bist_seq #(
  parameter int CHAIN_LEN  = 16,
  parameter int CHILD_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic flip_in,
  output logic scan_en,
  output logic scan_in,
  output logic capture_en,
  output logic child_en,
  output logic done
);
  localparam int SW = $clog2(CHAIN_LEN + 1);
  localparam int PW = CHILD_BITS + 2;

  typedef enum logic [2:0] {IDLE, LOAD, SHIFT, CAPT, FIN} st_t;

  st_t           st;
  logic [SW-1:0] sc;
  logic [PW-1:0] pc;

  wire [1:0] centre = pc[PW-1 -: 2];
  wire       wave   = (sc[1:0] != centre);

  assign scan_en    = (st == SHIFT);
  assign capture_en = (st == CAPT);
  assign done       = (st == FIN);
  assign child_en   = |pc[CHILD_BITS-1:0];
  assign scan_in    = scan_en & (wave ^ (flip_in & child_en));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      sc <= '0;
      pc <= '0;
    end else begin
      case (st)
        IDLE, FIN: if (start) begin
          st <= LOAD;
          pc <= '0;
        end
        LOAD: begin
          sc <= SW'(CHAIN_LEN);
          st <= SHIFT;
        end
        SHIFT: begin
          sc <= sc - 1'b1;
          if (sc == SW'(1)) st <= CAPT;
        end
        CAPT: begin
          pc <= pc + 1'b1;
          st <= (&pc) ? FIN : LOAD;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT && $past(st) == SHIFT) |-> sc == $past(sc) - 1'b1);

  assert_single_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> !capture_en);

  assert_capture_not_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture_en && scan_en));

  assert_centre_unflipped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && &pc[CHILD_BITS-1:0]) |=> !child_en);

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && start && !$past(capture_en)) |=> (scan_en || capture_en));
endmodule

// File: tb/test_star_bist_seq.sv
module test_star_bist_seq;
  localparam int CLK_P      = 10;
  localparam int CHAIN_LEN  = 16;
  localparam int CHILD_BITS = 4;
  localparam int GROUP      = 1 << CHILD_BITS;
  localparam int TOTAL      = 4 * GROUP;

  logic clk = 0, rst_n = 0, start = 0, flip_in = 0;
  logic scan_en, scan_in, capture_en, child_en, done;

  star_bist_seq #(.CHAIN_LEN(CHAIN_LEN), .CHILD_BITS(CHILD_BITS)) i_star_bist_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .flip_in(flip_in),
    .scan_en(scan_en), .scan_in(scan_in), .capture_en(capture_en),
    .child_en(child_en), .done(done));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    flip_in <= lfsr[0];
  end

  // behavioural reference: 0 idle, 1 load, 2 shift, 3 capture, 4 done
  int m_st = 0, m_pos = 0, m_pat = 0;
  int cap_cnt = 0, shift_k = 0, centres_ok = 0;
  logic [CHAIN_LEN-1:0] got;
  logic got_all_plain;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pos = 0; m_pat = 0;
    end else begin
      case (m_st)
        0, 4: if (start) begin m_st = 1; m_pat = 0; end
        1: begin m_pos = CHAIN_LEN; m_st = 2; end
        2: begin m_pos = m_pos - 1; if (m_pos == 0) m_st = 3; end
        3: begin m_pat = (m_pat + 1) % TOTAL; m_st = (m_pat == 0) ? 4 : 1; end
        default: m_st = 0;
      endcase
    end
    #(CLK_P/4);
    if (rst_n) begin : cmp
      logic e_child, e_wave;
      e_child = (m_pat % GROUP) != 0;
      e_wave  = (m_pos % 4) != (m_pat / GROUP);
      chk("R2 scan_en", scan_en, m_st == 2);
      chk("R5 capture_en", capture_en, m_st == 3);
      chk("R6 child_en", child_en, e_child);
      chk("R7 done", done, m_st == 4);
      if (m_st == 2)
        chk(e_child ? "R4 scan_in" : "R3 scan_in", scan_in, e_wave ^ (flip_in & e_child));
      else
        chk("R1 scan_in idle", scan_in, 1'b0);
      // independent centre-pattern capture from the ports
      if (scan_en) begin
        if (shift_k == 0) got_all_plain = 1'b1;
        if (shift_k < CHAIN_LEN) got[shift_k] = scan_in;
        if (child_en) got_all_plain = 1'b0;
        shift_k++;
      end
      if (capture_en) begin
        if ((cap_cnt % GROUP) == 0) begin : centre_chk
          int c;
          logic [CHAIN_LEN-1:0] exp_p;
          c = (cap_cnt % TOTAL) / GROUP;
          for (int k = 0; k < CHAIN_LEN; k++)
            exp_p[k] = ((CHAIN_LEN - k) % 4) != c;
          chk("R6 centre pattern child_en low", got_all_plain, 1'b1);
          checks++;
          if (got !== exp_p || shift_k != CHAIN_LEN) begin
            fails++;
            $display("FAIL R3 centre %0d actual=%h expected=%h shifts=%0d", c, got, exp_p, shift_k);
          end else centres_ok++;
        end
        cap_cnt++;
        shift_k = 0;
      end
    end
  end

  task automatic pulse_start;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) begin
      checks++; fails++;
      $display("FAIL R7 watchdog actual=not_done expected=done");
    end
  endtask

  initial begin : main
    bit ok;
    int base;
    repeat (3) @(negedge clk);
    chk("R1 reset scan_en", scan_en, 1'b0);
    chk("R1 reset capture_en", capture_en, 1'b0);
    chk("R1 reset child_en", child_en, 1'b0);
    chk("R1 reset done", done, 1'b0);
    chk("R1 reset scan_in", scan_in, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle done", done, 1'b0);

    base = cap_cnt;
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start(); // R9: ignored mid-run
    repeat (300) @(negedge clk);
    pulse_start(); // R9 again, later in the run
    wait_done(ok);
    if (ok) begin
      checks++;
      if (cap_cnt - base != TOTAL) begin
        fails++;
        $display("FAIL R7 capture count actual=%0d expected=%0d", cap_cnt - base, TOTAL);
      end
      checks++;
      if (centres_ok != 4) begin
        fails++;
        $display("FAIL R3 centres matched actual=%0d expected=4", centres_ok);
      end
      repeat (5) @(negedge clk);
      chk("R7 done held", done, 1'b1);

      base = cap_cnt;
      pulse_start(); // R8 restart
      chk("R8 done cleared on restart", done, 1'b0);
      wait_done(ok);
      checks++;
      if (cap_cnt - base != TOTAL || centres_ok != 8) begin
        fails++;
        $display("FAIL R8 restart captures actual=%0d/%0d expected=%0d/8",
                 cap_cnt - base, centres_ok, TOTAL);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule